// File: doc/BRIEF.md
# Host Bus Control and Interrupt Register Block

This block sits between a host processor bus and a high-speed data path built from a pair of FIFOs and an external byte-oriented bus controller. The host sees two 8-bit addresses. Address 0 is the control register on writes and the status register on reads. Address 1 is the configuration register. Control writes select standard mode, high-speed transmit or high-speed receive. Writing both mode bits set is not a mode: it is a one-shot clear command. Control writes also enable half-full interrupts, set the system-controller output and clear individual interrupt flags.

Four interrupt sources are latched on their rising edges: service request, end-of-transfer, half-full and transmit-empty. Each is cleared by its own write-one bit, and a set wins over a clear in the same cycle. The OR of the latched flags drives one of seven interrupt lines, chosen by a 3-bit select code held in the configuration register. Any configuration write sends a one-cycle flush pulse to both FIFOs. Bit 7 of that register holds the external controller in reset. The FIFOs and the controller are outside the block and appear only as flag inputs and clear outputs.

Top module: `hostif_ctl_regs`

## Requirements
- R1: A write to address 0 with bits 1:0 equal to 00, 01 or 10 sets `mode_o` to that value (0 standard, 1 high-speed transmit, 2 high-speed receive) from the next cycle on.
- R2: A write to address 0 with bits 1:0 equal to 11 acts as the clear command. It returns `mode_o` to 0, clears the half-full enable and `sys_ctl_o`, clears all four latched interrupt flags, enables the transmit-empty interrupt, and pulses `tx_sm_clr_o` high for exactly one cycle.
- R3: The half-full flag (status bit 1) sets on a rising edge of `tx_hf_i` in transmit mode or of `rx_hf_i` in receive mode, and only while control bit 3 (half-full enable) is 1. In standard mode, with the enable at 0, or on the input of the other direction, the edge is ignored.
- R4: The service-request flag (status bit 2) sets on a rising edge of `srq_i`, and the end-of-transfer flag (status bit 3) sets on a rising edge of `eoi_i`.
- R5: Writing 1 to control bit 4, 5 or 6 clears the service-request, end-of-transfer or half-full flag, and leaves the other flags alone. Bit 5 also clears the transmit-empty flag. A flag whose source rises in the same cycle as its clear ends up set.
- R6: The transmit-empty flag sets on a rising edge of `tx_empty_i` only after a clear command has enabled it. It has no status bit and is seen only through `irq_o`.
- R7: Control bit 7 of a write to address 0 that is not a clear command drives `sys_ctl_o` from the next cycle on.
- R8: Every write to address 1 pulses `fifo_clr_o` high for exactly one cycle. It stores bits 2:0 as the line select code and bit 7 as `ctlr_rst_o`.
- R9: With select code k from 1 to 7, `irq_o[k-1]` equals the OR of the four latched flags and every other line is low. With code 0 all lines are low. Lines 0 to 6 stand for request numbers 2, 3, 4, 5, 7, 10 and 11.
- R10: Status bit 0 is set while `tx_full_i` or `rx_full_i` is high and stays set until a write to address 1. A full input that is high during that write keeps it set. Status bits 7:4 equal `has_data_i[3:0]`.
- R11: `rdata_o` is 0 while `rd_i` is low. With `rd_i` high it returns the status at address 0, and at address 1 it returns {`ctlr_rst_o`, 4'b0, select code}.
- R12: After reset, `mode_o`, `sys_ctl_o`, `ctlr_rst_o`, `fifo_clr_o`, `tx_sm_clr_o`, all flags, the select code and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects control/status, 1 selects configuration |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, gates `rdata_o` |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| srq_i | input | 1 | Service-request source from the controller |
| eoi_i | input | 1 | End-of-transfer source from the controller |
| tx_empty_i | input | 1 | Transmit FIFO empty source |
| tx_hf_i | input | 1 | Transmit FIFO half-full level |
| rx_hf_i | input | 1 | Receive FIFO half-full level |
| tx_full_i | input | 1 | Transmit FIFO full level |
| rx_full_i | input | 1 | Receive FIFO full level |
| has_data_i | input | 4 | Contains-data flags: tx upper, rx upper, tx lower, rx lower byte FIFO |
| mode_o | output | 2 | Current mode: 0 standard, 1 transmit, 2 receive |
| tx_sm_clr_o | output | 1 | One-cycle reset for the transmit sequencer |
| sys_ctl_o | output | 1 | High when the card is system controller |
| ctlr_rst_o | output | 1 | Reset level for the byte controller |
| fifo_clr_o | output | 1 | One-cycle flush of both FIFOs |
| irq_o | output | 7 | Interrupt request lines, at most one active |

## Verification
A flag latched wrongly, or not cleared, shows one cycle later as a wrong bit in the status read and as the selected `irq_o` line held in the wrong state. The transmit-empty flag can only be seen through the line. A wrong decode of the clear command shows in the cycle after the write: `mode_o` and `sys_ctl_o` keep their old values, or the one-cycle `tx_sm_clr_o` pulse is missing or too long. A missed configuration flush shows as an absent `fifo_clr_o` pulse, and status bit 0 stays stuck high.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_SRC = 4;

  typedef enum logic [1:0] {
    MODE_STD = 2'd0,
    MODE_TX  = 2'd1,
    MODE_RX  = 2'd2,
    MODE_CLR = 2'd3
  } mode_e;

  // control write bits
  localparam int CTL_HF_EN   = 3;
  localparam int CTL_CLR_SRQ = 4;
  localparam int CTL_CLR_EOI = 5;
  localparam int CTL_CLR_HF  = 6;
  localparam int CTL_SC      = 7;
  // configuration bits
  localparam int CFG_RST     = 7;
  // flag vector indices
  localparam int SRC_SRQ = 0;
  localparam int SRC_EOI = 1;
  localparam int SRC_HF  = 2;
  localparam int SRC_TXE = 3;
endpackage

// File: rtl/hostif_mode_ctl.sv
module hostif_mode_ctl
  import hostif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mode_e             mode_o,
  output logic              hf_en_o,
  output logic              sc_o,
  output logic              txe_en_o,
  output logic              tx_sm_clr_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic clear_fn;
  assign clear_fn = wr_i && (wdata_i[1:0] == MODE_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= MODE_STD;
      hf_en_o     <= 1'b0;
      sc_o        <= 1'b0;
      txe_en_o    <= 1'b0;
      tx_sm_clr_o <= 1'b0;
    end else begin
      tx_sm_clr_o <= clear_fn;
      if (clear_fn) begin
        mode_o   <= MODE_STD;
        hf_en_o  <= 1'b0;
        sc_o     <= 1'b0;
        txe_en_o <= 1'b1;
      end else if (wr_i) begin
        mode_o  <= mode_e'(wdata_i[1:0]);
        hf_en_o <= wdata_i[CTL_HF_EN];
        sc_o    <= wdata_i[CTL_SC];
      end
    end
  end

  always_comb begin
    clr_o          = '0;
    clr_o[SRC_SRQ] = clear_fn | (wr_i & wdata_i[CTL_CLR_SRQ]);
    clr_o[SRC_EOI] = clear_fn | (wr_i & wdata_i[CTL_CLR_EOI]);
    clr_o[SRC_HF]  = clear_fn | (wr_i & wdata_i[CTL_CLR_HF]);
    clr_o[SRC_TXE] = clear_fn | (wr_i & wdata_i[CTL_CLR_EOI]);
  end
endmodule

// File: rtl/hostif_irq_flag.sv
module hostif_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic en_i,
  input  logic clr_i,
  output logic flag_o
);
  logic src_q;
  logic set;

  assign set = en_i & src_i & ~src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      src_q <= src_i;
      if (set)        flag_o <= 1'b1;  // set beats clear
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hostif_irq_route.sv
module hostif_irq_route #(
  parameter int SEL_W     = 3,
  parameter int NUM_LINES = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 any_i,
  output logic [NUM_LINES-1:0] irq_o
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    assign irq_o[k] = any_i && (sel_i == SEL_W'(k + 1));
  end
endmodule

// File: rtl/hostif_ctl_regs.sv
module hostif_ctl_regs
  import hostif_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int DATA_FLGS = 4,
  localparam int NUM_LINES = (1 << SEL_W) - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 srq_i,
  input  logic                 eoi_i,
  input  logic                 tx_empty_i,
  input  logic                 tx_hf_i,
  input  logic                 rx_hf_i,
  input  logic                 tx_full_i,
  input  logic                 rx_full_i,
  input  logic [DATA_FLGS-1:0] has_data_i,
  output logic [1:0]           mode_o,
  output logic                 tx_sm_clr_o,
  output logic                 sys_ctl_o,
  output logic                 ctlr_rst_o,
  output logic                 fifo_clr_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic ctl_wr, cfg_wr;
  assign ctl_wr = wr_i & ~addr_i;
  assign cfg_wr = wr_i & addr_i;

  mode_e              mode;
  logic               hf_en, txe_en;
  logic [NUM_SRC-1:0] clr, src, en, flags;

  hostif_mode_ctl u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctl_wr),
    .wdata_i    (wdata_i),
    .mode_o     (mode),
    .hf_en_o    (hf_en),
    .sc_o       (sys_ctl_o),
    .txe_en_o   (txe_en),
    .tx_sm_clr_o(tx_sm_clr_o),
    .clr_o      (clr)
  );
  assign mode_o = mode;

  // half-full source follows the active direction
  logic hf_src;
  always_comb begin
    case (mode)
      MODE_TX: hf_src = tx_hf_i;
      MODE_RX: hf_src = rx_hf_i;
      default: hf_src = 1'b0;
    endcase
  end

  always_comb begin
    src          = '0;
    en           = '0;
    src[SRC_SRQ] = srq_i;      en[SRC_SRQ] = 1'b1;
    src[SRC_EOI] = eoi_i;      en[SRC_EOI] = 1'b1;
    src[SRC_HF]  = hf_src;     en[SRC_HF]  = hf_en;
    src[SRC_TXE] = tx_empty_i; en[SRC_TXE] = txe_en;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    hostif_irq_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (src[g]),
      .en_i  (en[g]),
      .clr_i (clr[g]),
      .flag_o(flags[g])
    );
  end

  // configuration register
  logic [SEL_W-1:0] cfg_sel_q;
  logic             full_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_sel_q  <= '0;
      ctlr_rst_o <= 1'b0;
      fifo_clr_o <= 1'b0;
      full_q     <= 1'b0;
    end else begin
      fifo_clr_o <= cfg_wr;
      if (cfg_wr) begin
        cfg_sel_q  <= wdata_i[SEL_W-1:0];
        ctlr_rst_o <= wdata_i[CFG_RST];
      end
      if (tx_full_i | rx_full_i) full_q <= 1'b1;
      else if (cfg_wr)           full_q <= 1'b0;
    end
  end

  hostif_irq_route #(.SEL_W(SEL_W)) u_route (
    .sel_i(cfg_sel_q),
    .any_i(|flags),
    .irq_o(irq_o)
  );

  logic [DATA_W-1:0] status, cfg_rd;
  always_comb begin
    status    = {has_data_i, flags[SRC_EOI], flags[SRC_SRQ], flags[SRC_HF], full_q};
    cfg_rd    = '0;
    cfg_rd[SEL_W-1:0] = cfg_sel_q;
    cfg_rd[CFG_RST]   = ctlr_rst_o;
    rdata_o   = !rd_i ? '0 : (addr_i ? cfg_rd : status);
  end
endmodule

// File: rtl/hostif_ctl_regs_chk.sv
module hostif_ctl_regs_chk #(
  parameter int NUM_LINES = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 addr_i,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [7:0]           wdata_i,
  input logic [7:0]           rdata_o,
  input logic                 tx_full_i,
  input logic                 rx_full_i,
  input logic [1:0]           mode_o,
  input logic                 tx_sm_clr_o,
  input logic                 sys_ctl_o,
  input logic                 ctlr_rst_o,
  input logic                 fifo_clr_o,
  input logic [NUM_LINES-1:0] irq_o,
  input logic                 full_i,
  input logic                 hf_flag_i
);
  p_mode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[1:0] != 2'b11) |=> (mode_o == $past(wdata_i[1:0])));

  p_clear_fn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[1:0] == 2'b11) |=> (mode_o == 2'b00 && tx_sm_clr_o && !sys_ctl_o));

  p_hf_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00) |=> !$rose(hf_flag_i));

  p_sc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[1:0] != 2'b11) |=> (sys_ctl_o == $past(wdata_i[7])));

  p_fifo_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i) |=> (fifo_clr_o && ctlr_rst_o == $past(wdata_i[7])));

  p_fifo_clr_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i) |=> !fifo_clr_o);

  p_irq_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  p_irq_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && wdata_i[2:0] == 3'd0) |=> (irq_o == '0));

  p_full_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_i || rx_full_i) |=> full_i);

  p_rdata_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == 8'h00));
endmodule

bind hostif_ctl_regs hostif_ctl_regs_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .tx_full_i  (tx_full_i),
  .rx_full_i  (rx_full_i),
  .mode_o     (mode_o),
  .tx_sm_clr_o(tx_sm_clr_o),
  .sys_ctl_o  (sys_ctl_o),
  .ctlr_rst_o (ctlr_rst_o),
  .fifo_clr_o (fifo_clr_o),
  .irq_o      (irq_o),
  .full_i     (full_q),
  .hf_flag_i  (flags[hostif_pkg::SRC_HF])
);

// File: tb/hostif_ctl_regs_test.sv
module hostif_ctl_regs_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       srq_i = 0, eoi_i = 0, tx_empty_i = 0, tx_hf_i = 0, rx_hf_i = 0;
  logic       tx_full_i = 0, rx_full_i = 0;
  logic [3:0] has_data_i = 4'h0;
  logic [1:0] mode_o;
  logic       tx_sm_clr_o, sys_ctl_o, ctlr_rst_o, fifo_clr_o;
  logic [6:0] irq_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  hostif_ctl_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .srq_i(srq_i), .eoi_i(eoi_i),
    .tx_empty_i(tx_empty_i), .tx_hf_i(tx_hf_i), .rx_hf_i(rx_hf_i),
    .tx_full_i(tx_full_i), .rx_full_i(rx_full_i), .has_data_i(has_data_i),
    .mode_o(mode_o), .tx_sm_clr_o(tx_sm_clr_o), .sys_ctl_o(sys_ctl_o),
    .ctlr_rst_o(ctlr_rst_o), .fifo_clr_o(fifo_clr_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    rd_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       exp_hf;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R12 reset state
    chk(mode_o, 0, "R12 mode");
    chk({tx_sm_clr_o, sys_ctl_o, ctlr_rst_o, fifo_clr_o}, 0, "R12 outputs");
    chk(irq_o, 0, "R12 irq");
    rd_reg(1'b0, d); chk(d, 8'h00, "R12 status");
    rd_reg(1'b1, d); chk(d, 8'h00, "R12 config");

    // R11 idle read bus and R10 data flags
    has_data_i = 4'hF;
    #1 chk(rdata_o, 8'h00, "R11 rd low");
    for (int v = 0; v < 16; v++) begin
      has_data_i = 4'(v);
      rd_reg(1'b0, d);
      chk(d, {4'(v), 4'h0}, "R10 data flags");
    end
    has_data_i = 4'h0;

    // R8 config write, flush pulse, readback
    wr_reg(1'b1, 8'h01);
    chk(fifo_clr_o, 1, "R8 flush pulse");
    tick();
    chk(fifo_clr_o, 0, "R8 flush one cycle");
    rd_reg(1'b1, d); chk(d, 8'h01, "R11 config read");
    wr_reg(1'b1, 8'h81);
    chk(ctlr_rst_o, 1, "R8 ctlr reset set");
    rd_reg(1'b1, d); chk(d, 8'h81, "R11 config read rst");
    wr_reg(1'b1, 8'h01);
    chk(ctlr_rst_o, 0, "R8 ctlr reset release");

    // R6 transmit-empty disabled before any clear command
    tick(); tx_empty_i = 1; tick();
    chk(irq_o, 0, "R6 txe disabled");
    tx_empty_i = 0; tick();

    // R1 mode decode, R7 system controller
    for (int m = 0; m < 3; m++) begin
      wr_reg(1'b0, 8'(m));
      chk(mode_o, 32'(m), "R1 mode");
      chk(tx_sm_clr_o, 0, "R1 no clear pulse");
    end
    wr_reg(1'b0, 8'h81);
    chk({sys_ctl_o, mode_o}, 3'b101, "R7 sc set");
    wr_reg(1'b0, 8'h00);
    chk(sys_ctl_o, 0, "R7 sc clear");

    // R4 latch srq/eoi, then R2 clear command
    srq_i = 1; tick(); srq_i = 0;
    eoi_i = 1; tick(); eoi_i = 0;
    rd_reg(1'b0, d); chk(d, 8'h0C, "R4 srq+eoi latched");
    wr_reg(1'b0, 8'h89);
    chk({sys_ctl_o, mode_o}, 3'b101, "R7 sc before clear");
    wr_reg(1'b0, 8'h8B);
    chk({sys_ctl_o, mode_o}, 0, "R2 ctrl bits zero");
    chk(tx_sm_clr_o, 1, "R2 sequencer pulse");
    rd_reg(1'b0, d); chk(d, 8'h00, "R2 flags cleared");
    tick();
    chk(tx_sm_clr_o, 0, "R2 pulse one cycle");

    // R6 transmit-empty now enabled; R5 bit5 clears it
    tx_empty_i = 1; tick(); tx_empty_i = 0;
    chk(irq_o, 7'h01, "R6 txe irq");
    rd_reg(1'b0, d); chk(d, 8'h00, "R6 txe not in status");
    wr_reg(1'b0, 8'h20);
    chk(irq_o, 0, "R5 eoi clear drops txe");

    // R3 half-full sweep: mode x enable x direction
    for (int m = 0; m < 3; m++)
      for (int e = 0; e < 2; e++)
        for (int dir = 0; dir < 2; dir++) begin
          wr_reg(1'b0, 8'h03);
          wr_reg(1'b0, 8'((e << 3) | m));
          if (dir == 0) tx_hf_i = 1; else rx_hf_i = 1;
          tick();
          tx_hf_i = 0; rx_hf_i = 0;
          exp_hf = (e == 1) && ((m == 1 && dir == 0) || (m == 2 && dir == 1));
          rd_reg(1'b0, d);
          chk(d[1], exp_hf, $sformatf("R3 hf m=%0d en=%0d dir=%0d", m, e, dir));
          chk(irq_o, {6'b0, exp_hf}, "R3 hf irq");
          wr_reg(1'b0, 8'(8'h40 | (e << 3) | m));
          rd_reg(1'b0, d);
          chk(d[1], 0, "R5 hf clear");
        end
    wr_reg(1'b0, 8'h03);

    // R5 individual clears
    srq_i = 1; tick(); srq_i = 0;
    eoi_i = 1; tick(); eoi_i = 0;
    wr_reg(1'b0, 8'h10);
    rd_reg(1'b0, d); chk(d, 8'h08, "R5 srq clear only");
    wr_reg(1'b0, 8'h40);
    rd_reg(1'b0, d); chk(d, 8'h08, "R5 hf clear leaves eoi");
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, d); chk(d, 8'h00, "R5 eoi clear");
    // set wins over clear
    @(negedge clk);
    addr_i = 0; wdata_i = 8'h10; wr_i = 1; srq_i = 1;
    tick();
    wr_i = 0; srq_i = 0;
    rd_reg(1'b0, d); chk(d[2], 1, "R5 set wins");

    // R9 routing sweep with srq flag set
    for (int s = 0; s < 8; s++) begin
      wr_reg(1'b1, 8'(s));
      chk(irq_o, (s == 0) ? 0 : (1 << (s - 1)), $sformatf("R9 sel %0d", s));
    end
    wr_reg(1'b0, 8'h10);
    chk(irq_o, 0, "R9 no flags");
    eoi_i = 1; tick(); eoi_i = 0;
    chk(irq_o, 7'h40, "R9 eoi on line 6");
    wr_reg(1'b0, 8'h20);

    // R10 sticky full
    tx_full_i = 1; tick(); tx_full_i = 0;
    tick(); tick();
    rd_reg(1'b0, d); chk(d[0], 1, "R10 full sticky tx");
    wr_reg(1'b1, 8'h00);
    rd_reg(1'b0, d); chk(d[0], 0, "R10 full cleared");
    @(negedge clk);
    addr_i = 1; wdata_i = 8'h00; wr_i = 1; rx_full_i = 1;
    tick();
    wr_i = 0; rx_full_i = 0;
    rd_reg(1'b0, d); chk(d[0], 1, "R10 full set wins");
    wr_reg(1'b1, 8'h00);
    rd_reg(1'b0, d); chk(d[0], 0, "R10 full cleared again");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule